// File: doc/BRIEF.md
# Partial Address Decoder with Aliasing

This block sits between a small processor with a 16-bit address bus and 8-bit data, and two storage devices of 4 KB each: a read-write RAM and a read-only ROM. It produces a chip select for each device, the 12-bit byte offset inside the device, a write enable for the RAM, and the read data returned to the processor. Bit 15 of the address chooses the device: 0 for RAM, 1 for ROM. Bits 11:0 choose the byte.

Decoding is incomplete on purpose. Bits 14:12 are not looked at, so every device answers at eight addresses that differ only in those bits. The map a programmer is meant to use is RAM at 0x0000-0x0FFF and ROM at 0x8000-0x8FFF. Any other address still reaches one of the two devices. A flag reports such addresses but changes nothing about the access. A write aimed at ROM still selects the ROM, but no write enable is ever produced for it. Its contents stay as they were, and no error is signalled.

The block is purely combinational. Read data follows the selected device in the same cycle as the read strobe.

Top module: `alias_decoder`

## Requirements
- R1: The offset output always equals address bits 11:0, whatever the strobes and the upper bits.
- R2: With a read or write strobe active, address bit 15 = 0 asserts only the RAM select and bit 15 = 1 asserts only the ROM select. With no strobe active, neither select is asserted.
- R3: Address bits 14:12 do not affect selection, offset, write enable or read data. For example, 0x4567 reaches RAM byte 0x567, and 0xF123 reaches ROM byte 0x123.
- R4: The RAM write enable is asserted exactly when the write strobe is active and address bit 15 is 0.
- R5: A write with address bit 15 = 1 asserts the ROM select but no write enable. A later read of that ROM byte returns its original contents.
- R6: While the read strobe is active, the read data equals the selected device's data in the same cycle. While it is inactive, the read data is 0x00.
- R7: The out-of-map flag is 1 exactly when any of address bits 14:12 is 1, independent of the strobes. It does not change the selects, the write enable or the read data.
- R8: The RAM write data output always equals the write data input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 16 | Processor address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Processor write data |
| ram_rdata_i | input | 8 | Data returned by the RAM |
| rom_rdata_i | input | 8 | Data returned by the ROM |
| ram_cs_o | output | 1 | RAM chip select |
| rom_cs_o | output | 1 | ROM chip select |
| offset_o | output | 12 | Byte offset inside the selected device |
| ram_we_o | output | 1 | RAM write enable |
| ram_wdata_o | output | 8 | Data written to the RAM |
| rdata_o | output | 8 | Read data returned to the processor |
| out_of_map_o | output | 1 | Address lies outside the documented windows |

## Verification
The assertions check, whenever the inputs change, that the two selects are never active together and never active without a strobe. They also check that the RAM write enable only appears with a write into RAM, that a ROM select never comes with a write enable, and that idle read data is zero. Only the bench's scenarios, which use behavioural memories, can show what aliasing does to stored data. Those scenarios write through one alias, read back through another, and confirm that a write attempted on ROM leaves the byte unchanged.

// File: rtl/alias_decoder.sv
module alias_decoder #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int OFF_W  = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] ram_rdata_i,
  input  logic [DATA_W-1:0] rom_rdata_i,
  output logic              ram_cs_o,
  output logic              rom_cs_o,
  output logic [OFF_W-1:0]  offset_o,
  output logic              ram_we_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              out_of_map_o
);
  localparam int SEL_BIT = ADDR_W - 1;

  logic active;
  logic dev_rom;

  assign active  = rd_i | wr_i;
  assign dev_rom = addr_i[SEL_BIT];

  assign offset_o     = addr_i[OFF_W-1:0];
  assign ram_cs_o     = active & ~dev_rom;
  assign rom_cs_o     = active & dev_rom;
  assign ram_we_o     = wr_i & ~dev_rom;
  assign ram_wdata_o  = wdata_i;
  assign out_of_map_o = |addr_i[SEL_BIT-1:OFF_W];

  always_comb begin
    rdata_o = '0;
    if (rd_i) rdata_o = dev_rom ? rom_rdata_i : ram_rdata_i;
  end
endmodule

module alias_decoder_chk #(
  parameter int DATA_W = 8
) (
  input logic              rd_i,
  input logic              wr_i,
  input logic              ram_cs_o,
  input logic              rom_cs_o,
  input logic              ram_we_o,
  input logic [DATA_W-1:0] ram_rdata_i,
  input logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    // R2
    one_sel_chk: assert ($onehot0({ram_cs_o, rom_cs_o}));
    // R2
    sel_needs_strobe_chk: assert (!(ram_cs_o || rom_cs_o) || rd_i || wr_i);
    // R4
    we_needs_ram_write_chk: assert (!ram_we_o || (wr_i && ram_cs_o));
    // R5
    rom_no_we_chk: assert (!(rom_cs_o && ram_we_o));
    // R6
    idle_rdata_zero_chk: assert (rd_i || rdata_o == '0);
    // R6
    ram_read_path_chk: assert (!(rd_i && ram_cs_o) || rdata_o == ram_rdata_i);
  end
endmodule

bind alias_decoder alias_decoder_chk #(.DATA_W(DATA_W)) u_chk (
  .rd_i(rd_i), .wr_i(wr_i), .ram_cs_o(ram_cs_o), .rom_cs_o(rom_cs_o),
  .ram_we_o(ram_we_o), .ram_rdata_i(ram_rdata_i), .rdata_o(rdata_o)
);

// File: tb/tb_alias_decoder.sv
module tb_alias_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [15:0] addr = '0;
  logic rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] ram_rd, rom_rd;
  logic ram_cs, rom_cs, ram_we, oom;
  logic [11:0] off;
  logic [7:0] ram_wd, rdata;

  logic [7:0] ram_mem [4096];

  int tests = 0, fails = 0;

  function automatic logic [7:0] rom_val(input logic [11:0] o);
    return o[7:0] ^ {o[11:8], 4'h5};
  endfunction

  assign ram_rd = ram_mem[off];
  assign rom_rd = rom_val(off);

  always_ff @(posedge clk)
    if (ram_we) ram_mem[off] <= ram_wd;

  alias_decoder dut (
    .addr_i(addr), .rd_i(rd), .wr_i(wr), .wdata_i(wdata),
    .ram_rdata_i(ram_rd), .rom_rdata_i(rom_rd),
    .ram_cs_o(ram_cs), .rom_cs_o(rom_cs), .offset_o(off),
    .ram_we_o(ram_we), .ram_wdata_o(ram_wd), .rdata_o(rdata),
    .out_of_map_o(oom)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic r, input logic w, input logic [7:0] d);
    @(negedge clk);
    addr = a; rd = r; wr = w; wdata = d;
    #1;
  endtask

  task automatic idle();
    drive(16'h0000, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic t_reset_idle();
    drive(16'hF7AB, 1'b0, 1'b0, 8'h3C);
    check("R2 idle ram_cs", ram_cs, 0);
    check("R2 idle rom_cs", rom_cs, 0);
    check("R6 idle rdata", rdata, 8'h00);
    check("R4 idle we", ram_we, 0);
    check("R1 idle offset", off, 12'h7AB);
    check("R7 flag idle", oom, 1);
    check("R8 wdata", ram_wd, 8'h3C);
  endtask

  task automatic t_ram_rw();
    drive(16'h0123, 1'b0, 1'b1, 8'hA5);
    check("R4 ram we", ram_we, 1);
    check("R2 ram_cs on write", ram_cs, 1);
    check("R7 flag in map", oom, 0);
    drive(16'h0123, 1'b1, 1'b0, 8'h00);
    check("R2 ram_cs on read", ram_cs, 1);
    check("R2 rom_cs off", rom_cs, 0);
    check("R6 ram read", rdata, 8'hA5);
    idle();
  endtask

  task automatic t_ram_alias();
    drive(16'h4567, 1'b0, 1'b1, 8'h5E);
    check("R3 alias we", ram_we, 1);
    check("R3 alias offset", off, 12'h567);
    check("R7 flag alias", oom, 1);
    drive(16'h0567, 1'b1, 1'b0, 8'h00);
    check("R3 alias readback base", rdata, 8'h5E);
    drive(16'h7567, 1'b1, 1'b0, 8'h00);
    check("R3 alias readback 7xxx", rdata, 8'h5E);
    check("R7 flag no effect on read", ram_cs, 1);
    idle();
  endtask

  task automatic t_rom_read();
    drive(16'h8123, 1'b1, 1'b0, 8'h00);
    check("R2 rom_cs", rom_cs, 1);
    check("R2 ram_cs off", ram_cs, 0);
    check("R6 rom read", rdata, rom_val(12'h123));
    drive(16'hF123, 1'b1, 1'b0, 8'h00);
    check("R3 rom alias", rdata, rom_val(12'h123));
    check("R1 rom alias offset", off, 12'h123);
    idle();
  endtask

  task automatic t_rom_write();
    drive(16'h8FFF, 1'b0, 1'b1, 8'h00);
    check("R5 rom write cs", rom_cs, 1);
    check("R5 rom write no we", ram_we, 0);
    drive(16'h0FFF, 1'b1, 1'b0, 8'h00);
    check("R5 ram byte untouched", rdata, 8'h00);
    drive(16'h8FFF, 1'b1, 1'b0, 8'h00);
    check("R5 rom unchanged", rdata, rom_val(12'hFFF));
    idle();
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 8; i++) begin
      drive({1'b0, i[2:0], 12'h0AA}, 1'b1, 1'b0, 8'h00);
      check("R7 sweep flag", oom, (i != 0));
      check("R3 sweep ram", rdata, ram_mem[12'h0AA]);
      drive({1'b1, i[2:0], 12'h0AA}, 1'b0, 1'b0, 8'h00);
      check("R2 sweep no strobe", rom_cs, 0);
      check("R6 sweep idle", rdata, 0);
    end
    idle();
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) ram_mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_idle();
    t_ram_rw();
    t_ram_alias();
    t_rom_read();
    t_rom_write();
    t_sweep();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #100000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule